// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block drives the command pins of a single-data-rate SDRAM device. A client hands it one access at a time, a read or a write addressed by bank, row and column. For each access it opens the row, issues the column command, lets the data beats run and closes the bank again, so no row stays open between accesses. Every nanosecond minimum the memory imposes is turned into a whole number of clocks when the block is elaborated. The clock period is divided into each time and the result is rounded up. The block then spaces its commands by loading a single countdown of idle clocks after each command it issues.

Out of reset it waits a programmable power-up delay, closes every bank, runs two refresh cycles and programs the mode word with the burst length and CAS latency. Only then does it take requests. From that point an interval timer raises a refresh demand at a fixed number of clocks. The demand is served as soon as the current access has closed its bank, and it wins over a waiting request. Two strobes tell the data path when write data must be on the bus and when read data arrives.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is held, and during the power-up wait, the pins carry NOP {cs_n,ras_n,cas_n,we_n}=0111, req_ready and init_done are 0, and both data strobes are 0. Other codes: ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, MODE SET 0000.
- R2: Initialisation issues PRECHARGE with address bit 10 high no earlier than POWERUP_CLK clocks after reset. REFRESH follows 3 clocks later, a second REFRESH 9 clocks after that, and MODE SET 9 clocks after that. MODE SET has bank 0 and address = CAS latency in bits [6:4], 0 in bit 3 and log2(burst) in bits [2:0], which is 0x032 by default.
- R3: ACTIVE carries the request's bank and row. The READ or WRITE follows exactly 3 clocks later (20 ns at 7.5 ns rounded up) with the same bank, the column in the low address bits and address bit 10 low.
- R4: For a write, wr_data_en is high for 4 clocks starting in the WRITE cycle. The closing PRECHARGE comes exactly 2 clocks after the last beat, and never sooner than 6 clocks (45 ns) after ACTIVE.
- R5: For a read, rd_data_valid is high for 4 clocks starting 3 clocks after READ. PRECHARGE comes 4 clocks after READ. The two strobes are never high together.
- R6: The next ACTIVE comes at least 3 clocks (precharge time) after PRECHARGE and at least 9 clocks (65 ns) after the previous ACTIVE. With a request waiting, ACTIVE-to-ACTIVE is exactly 11 clocks after a write and 10 after a read.
- R7: MODE SET is followed by 2 clocks before any other command. MODE SET and REFRESH are only issued while no bank is open.
- R8: Once initialised and idle, the block issues REFRESH every 1040 clocks. After any REFRESH the next command waits 9 clocks.
- R9: A pending refresh is served before a waiting request once the current access has closed. Under a continuous request stream, REFRESH spacing stays within 1040 to 1051 clocks.
- R10: req_ready is high only when the block is idle, its spacing has elapsed and no refresh is pending. A request is taken on a clock where req_valid and req_ready are both high, and each taken request yields exactly one ACTIVE.
- R11: The closing PRECHARGE of an access addresses the access's bank with address bit 10 low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Bank of the access |
| req_row | input | ROW_W | Row of the access |
| req_col | input | COL_W | Column of the access |
| req_ready | output | 1 | Request is taken this clock if valid |
| init_done | output | 1 | Initialisation sequence finished |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Multiplexed row/column/mode address |
| wr_data_en | output | 1 | Write data must be driven this clock |
| rd_data_valid | output | 1 | Read data is on the bus this clock |

## Verification
The bench times each command against the one before it. A rounding error in the clock conversion, or write recovery counted from the WRITE command instead of the last beat, would show up as a precharge one or more clocks early. A read and a write are mixed back to back, so a sequencer that used one closing delay for both would give the wrong ACTIVE-to-ACTIVE spacing on one of them. A refresh is forced to fall due while requests keep arriving. A design that let requests win would never refresh, and one that ignored the row cycle after REFRESH would open a row too early.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

   // {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_MRS   = 4'b0000,
      CMD_REF   = 4'b0001,
      CMD_PRE   = 4'b0010,
      CMD_ACT   = 4'b0011,
      CMD_WR    = 4'b0100,
      CMD_RD    = 4'b0101,
      CMD_NOP   = 4'b0111,
      CMD_DESEL = 4'b1111
   } sd_cmd_e;

   typedef enum logic [2:0] {
      ST_INIT_PRE  = 3'd0,
      ST_INIT_REF1 = 3'd1,
      ST_INIT_REF2 = 3'd2,
      ST_INIT_MRS  = 3'd3,
      ST_IDLE      = 3'd4,
      ST_COL       = 3'd5,
      ST_PRE       = 3'd6
   } seq_state_e;

   // whole clocks covering a time in picoseconds
   function automatic int clk_ceil(input int t_ps, input int period_ps);
      return (t_ps + period_ps - 1) / period_ps;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdram_gap_counter.sv
module sdram_gap_counter #(
   parameter int W       = 8,
   parameter int RST_VAL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= W'(RST_VAL);
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

   // a nonzero spacing must hold off the next command
   assert_gap_holds_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (load && load_val != '0) |=> !zero);

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
   parameter int INTERVAL = 1040
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic ack,
   output logic pending
);
   localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

   logic [CW-1:0] cnt;
   logic          tick;

   assign tick = enable && (cnt == CW'(INTERVAL - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '0;
         pending <= 1'b0;
      end else begin
         if (!enable)   cnt <= '0;
         else if (tick) cnt <= '0;
         else           cnt <= cnt + 1'b1;

         if (tick)      pending <= 1'b1;
         else if (ack)  pending <= 1'b0;
      end
   end

   // a raised demand stays until the sequencer serves it
   assert_pending_holds_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !ack) |=> pending);

   initial begin
      assert (INTERVAL >= 2) else $error("refresh interval too short");
   end

endmodule

// File: rtl/sdram_beat_track.sv
module sdram_beat_track #(
   parameter int CAS_LAT     = 3,
   parameter int BURST_BEATS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_go,
   input  logic rd_go,
   output logic wr_data_en,
   output logic rd_data_valid
);
   localparam int BW = $clog2(BURST_BEATS + 1);

   logic [BW-1:0]      wr_left;
   logic [BW-1:0]      rd_left;
   logic [CAS_LAT-1:0] rd_dly;

   // rd_dly[k] is high k clocks after the READ appears on the pins
   always_ff @(posedge clk) begin
      if (!rst_n) rd_dly[0] <= 1'b0;
      else        rd_dly[0] <= rd_go;
   end

   generate
      for (genvar i = 1; i < CAS_LAT; i++) begin : g_lat
         always_ff @(posedge clk) begin
            if (!rst_n) rd_dly[i] <= 1'b0;
            else        rd_dly[i] <= rd_dly[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_left <= '0;
         rd_left <= '0;
      end else begin
         if (wr_go)              wr_left <= BW'(BURST_BEATS);
         else if (wr_left != '0) wr_left <= wr_left - 1'b1;

         if (rd_dly[CAS_LAT-1])  rd_left <= BW'(BURST_BEATS);
         else if (rd_left != '0) rd_left <= rd_left - 1'b1;
      end
   end

   assign wr_data_en    = (wr_left != '0);
   assign rd_data_valid = (rd_left != '0);

   assert_no_bus_clash_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_data_en && rd_data_valid));

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
   import sdram_seq_pkg::*;
#(
   parameter int BANK_W = 2,
   parameter int ADDR_W = 13,
   parameter int AP_BIT = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sd_cmd_e           cmd_d,
   input  logic [BANK_W-1:0] ba_d,
   input  logic [ADDR_W-1:0] addr_d,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BANK_W-1:0] sd_ba,
   output logic [ADDR_W-1:0] sd_addr
);
   sd_cmd_e cmd_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q   <= CMD_NOP;
         sd_ba   <= '0;
         sd_addr <= '0;
      end else begin
         cmd_q   <= cmd_d;
         sd_ba   <= ba_d;
         sd_addr <= addr_d;
      end
   end

   assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

   // column commands never request automatic closing
   assert_col_no_autoclose_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_RD ||
       {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_WR) |-> !sd_addr[AP_BIT]);

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
   import sdram_seq_pkg::*;
#(
   parameter int CLK_PS        = 7500,
   parameter int T_RCD_PS      = 20000,
   parameter int T_RP_PS       = 20000,
   parameter int T_RAS_PS      = 45000,
   parameter int T_RC_PS       = 65000,
   parameter int T_RRD_PS      = 15000,
   parameter int WR_RECOV_CLK  = 2,
   parameter int MRS_CLK       = 2,
   parameter int REFI_CLK      = 1040,
   parameter int POWERUP_CLK   = 26667,
   parameter int CAS_LAT       = 3,
   parameter int BURST_BEATS   = 4,
   parameter int BANK_W        = 2,
   parameter int ROW_W         = 13,
   parameter int COL_W         = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   output logic              req_ready,
   output logic              init_done,
   output logic              sd_cs_n,
   output logic              sd_ras_n,
   output logic              sd_cas_n,
   output logic              sd_we_n,
   output logic [BANK_W-1:0] sd_ba,
   output logic [ROW_W-1:0]  sd_addr,
   output logic              wr_data_en,
   output logic              rd_data_valid
);
   localparam int AP_BIT  = 10;
   localparam int RCD_CLK = clk_ceil(T_RCD_PS, CLK_PS);
   localparam int RP_CLK  = clk_ceil(T_RP_PS,  CLK_PS);
   localparam int RAS_CLK = clk_ceil(T_RAS_PS, CLK_PS);
   localparam int RC_CLK  = clk_ceil(T_RC_PS,  CLK_PS);
   localparam int RRD_CLK = clk_ceil(T_RRD_PS, CLK_PS);

   // column command to precharge: write waits for recovery after its last beat
   localparam int WR_PRE_OFS = imax(BURST_BEATS - 1 + WR_RECOV_CLK, RAS_CLK - RCD_CLK);
   localparam int RD_PRE_OFS = imax(BURST_BEATS, RAS_CLK - RCD_CLK);
   localparam int WR_PRE_AT  = RCD_CLK + WR_PRE_OFS;
   localparam int RD_PRE_AT  = RCD_CLK + RD_PRE_OFS;
   // precharge to next command: precharge time, row cycle and activate spacing
   localparam int WR_NEXT = imax(RP_CLK, imax(RC_CLK - WR_PRE_AT, RRD_CLK - WR_PRE_AT));
   localparam int RD_NEXT = imax(RP_CLK, imax(RC_CLK - RD_PRE_AT, RRD_CLK - RD_PRE_AT));

   localparam int GAP_MAX = imax(imax(POWERUP_CLK, RC_CLK), imax(WR_PRE_OFS, MRS_CLK));
   localparam int GAP_W   = $clog2(GAP_MAX + 1);

   localparam logic [ROW_W-1:0] MODE_WORD =
      ROW_W'((CAS_LAT << 4) | $clog2(BURST_BEATS));

   initial begin
      assert (CAS_LAT == 2 || CAS_LAT == 3) else $error("CAS latency must be 2 or 3");
      assert (BURST_BEATS == 1 || BURST_BEATS == 2 || BURST_BEATS == 4 || BURST_BEATS == 8)
         else $error("burst must be 1, 2, 4 or 8");
      assert (ROW_W > AP_BIT && COL_W <= AP_BIT) else $error("address widths");
      assert (RCD_CLK >= 2 && RP_CLK >= 1 && MRS_CLK >= 2) else $error("spacing too short");
      assert (longint'(REFI_CLK) * longint'(CLK_PS) <= 64'd7812500)
         else $error("refresh interval exceeds 64 ms / 8192");
   end

   seq_state_e          state, nxt_state;
   sd_cmd_e             cmd_d;
   logic [BANK_W-1:0]   ba_d, bank_q;
   logic [ROW_W-1:0]    addr_d;
   logic [COL_W-1:0]    col_q;
   logic                wr_q;
   logic                gap_zero, gap_load;
   logic [GAP_W-1:0]    gap_val;
   logic                ref_pend, ref_ack, accept, wr_go, rd_go;

   assign init_done = (state == ST_IDLE) || (state == ST_COL) || (state == ST_PRE);
   assign req_ready = (state == ST_IDLE) && gap_zero && !ref_pend;

   always_comb begin
      nxt_state = state;
      cmd_d     = CMD_NOP;
      ba_d      = '0;
      addr_d    = '0;
      gap_load  = 1'b0;
      gap_val   = '0;
      ref_ack   = 1'b0;
      accept    = 1'b0;
      wr_go     = 1'b0;
      rd_go     = 1'b0;
      if (gap_zero) begin
         unique case (state)
            ST_INIT_PRE: begin
               cmd_d          = CMD_PRE;
               addr_d[AP_BIT] = 1'b1;
               gap_load       = 1'b1;
               gap_val        = GAP_W'(RP_CLK - 1);
               nxt_state      = ST_INIT_REF1;
            end
            ST_INIT_REF1: begin
               cmd_d     = CMD_REF;
               gap_load  = 1'b1;
               gap_val   = GAP_W'(RC_CLK - 1);
               nxt_state = ST_INIT_REF2;
            end
            ST_INIT_REF2: begin
               cmd_d     = CMD_REF;
               gap_load  = 1'b1;
               gap_val   = GAP_W'(RC_CLK - 1);
               nxt_state = ST_INIT_MRS;
            end
            ST_INIT_MRS: begin
               cmd_d     = CMD_MRS;
               addr_d    = MODE_WORD;
               gap_load  = 1'b1;
               gap_val   = GAP_W'(MRS_CLK - 1);
               nxt_state = ST_IDLE;
            end
            ST_IDLE: begin
               if (ref_pend) begin
                  cmd_d    = CMD_REF;
                  ref_ack  = 1'b1;
                  gap_load = 1'b1;
                  gap_val  = GAP_W'(RC_CLK - 1);
               end else if (req_valid) begin
                  cmd_d     = CMD_ACT;
                  ba_d      = req_bank;
                  addr_d    = req_row;
                  accept    = 1'b1;
                  gap_load  = 1'b1;
                  gap_val   = GAP_W'(RCD_CLK - 1);
                  nxt_state = ST_COL;
               end
            end
            ST_COL: begin
               cmd_d              = wr_q ? CMD_WR : CMD_RD;
               ba_d               = bank_q;
               addr_d[COL_W-1:0]  = col_q;
               wr_go              = wr_q;
               rd_go              = !wr_q;
               gap_load           = 1'b1;
               gap_val            = wr_q ? GAP_W'(WR_PRE_OFS - 1) : GAP_W'(RD_PRE_OFS - 1);
               nxt_state          = ST_PRE;
            end
            ST_PRE: begin
               cmd_d     = CMD_PRE;
               ba_d      = bank_q;
               gap_load  = 1'b1;
               gap_val   = wr_q ? GAP_W'(WR_NEXT - 1) : GAP_W'(RD_NEXT - 1);
               nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_INIT_PRE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_INIT_PRE;
         bank_q <= '0;
         col_q  <= '0;
         wr_q   <= 1'b0;
      end else begin
         state <= nxt_state;
         if (accept) begin
            bank_q <= req_bank;
            col_q  <= req_col;
            wr_q   <= req_write;
         end
      end
   end

   sdram_gap_counter #(.W(GAP_W), .RST_VAL(POWERUP_CLK)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (gap_load),
      .load_val (gap_val),
      .zero     (gap_zero)
   );

   sdram_refresh_timer #(.INTERVAL(REFI_CLK)) u_refi (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (init_done),
      .ack     (ref_ack),
      .pending (ref_pend)
   );

   sdram_beat_track #(.CAS_LAT(CAS_LAT), .BURST_BEATS(BURST_BEATS)) u_beats (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_go         (wr_go),
      .rd_go         (rd_go),
      .wr_data_en    (wr_data_en),
      .rd_data_valid (rd_data_valid)
   );

   sdram_cmd_drive #(.BANK_W(BANK_W), .ADDR_W(ROW_W), .AP_BIT(AP_BIT)) u_drive (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_d    (cmd_d),
      .ba_d     (ba_d),
      .addr_d   (addr_d),
      .sd_cs_n  (sd_cs_n),
      .sd_ras_n (sd_ras_n),
      .sd_cas_n (sd_cas_n),
      .sd_we_n  (sd_we_n),
      .sd_ba    (sd_ba),
      .sd_addr  (sd_addr)
   );

   // row-open tracking from the pins, separate from the sequencer state
   logic [3:0] pin_cmd;
   logic       row_open;
   assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

   always_ff @(posedge clk) begin
      if (!rst_n)                  row_open <= 1'b0;
      else if (pin_cmd == CMD_ACT) row_open <= 1'b1;
      else if (pin_cmd == CMD_PRE) row_open <= 1'b0;
   end

   assert_act_then_nop_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (pin_cmd == CMD_ACT) |=> (pin_cmd == CMD_NOP));

   assert_mode_gap_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (pin_cmd == CMD_MRS) |=> (pin_cmd == CMD_NOP));

   assert_closed_banks_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (pin_cmd == CMD_REF || pin_cmd == CMD_MRS) |-> !row_open);

   assert_ready_when_closed_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!row_open && init_done));

   assert_refresh_spacing_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (pin_cmd == CMD_REF) |=> (pin_cmd == CMD_NOP));

endmodule

// File: tb/tb_sdram_cmd_seq.sv
module tb_sdram_cmd_seq;
   localparam int PWR = 20;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write;
   logic [1:0]  req_bank;
   logic [12:0] req_row;
   logic [8:0]  req_col;
   logic        req_ready, init_done;
   logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [1:0]  sd_ba;
   logic [12:0] sd_addr;
   logic        wr_data_en, rd_data_valid;

   always #5 clk = ~clk;

   sdram_cmd_seq #(.POWERUP_CLK(PWR)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .req_ready(req_ready), .init_done(init_done),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
      .sd_ba(sd_ba), .sd_addr(sd_addr),
      .wr_data_en(wr_data_en), .rd_data_valid(rd_data_valid)
   );

   // vector: {write, bank[1:0], row[12:0], col[8:0]}
   localparam int NV = 6;
   localparam logic [24:0] VEC [NV] = '{
      {1'b1, 2'd0, 13'h0123, 9'h004},
      {1'b0, 2'd1, 13'h1FFF, 9'h1F8},
      {1'b0, 2'd3, 13'h0000, 9'h000},
      {1'b1, 2'd2, 13'h0A5A, 9'h155},
      {1'b1, 2'd1, 13'h1555, 9'h0AA},
      {1'b0, 2'd0, 13'h0404, 9'h1FF}
   };

   int checks = 0, errors = 0;
   int cyc = 0;

   // pin monitor records, indexed by access number
   int act_t [64]; int act_row [64]; int act_ba [64];
   int col_t [64]; int col_wr [64]; int col_addr [64]; int col_ba [64];
   int pre_t [64]; int pre_ba [64]; int pre_a10 [64];
   int wr_n [64]; int wr_first [64]; int wr_last [64];
   int rd_n [64]; int rd_first [64];
   int ref_t [16];
   int n_act = 0, n_ref = 0;
   int pa_t = -1, mrs_t = -1, mrs_addr = -1, mrs_ba = -1;
   int aft_ref_t = -2;

   always @(negedge clk) begin
      if (rst_n) begin
         int k;
         cyc++;
         k = (n_act > 0) ? ((n_act - 1) % 64) : 0;
         case ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n})
            4'b0011: begin
               act_t[n_act % 64] = cyc; act_row[n_act % 64] = sd_addr;
               act_ba[n_act % 64] = sd_ba; n_act++;
               if (aft_ref_t == -1) aft_ref_t = cyc;
            end
            4'b0101, 4'b0100: begin
               col_t[k] = cyc; col_wr[k] = !sd_we_n; col_addr[k] = sd_addr; col_ba[k] = sd_ba;
            end
            4'b0010: begin
               if (sd_addr[10]) pa_t = cyc;
               else begin pre_t[k] = cyc; pre_ba[k] = sd_ba; pre_a10[k] = 0; end
            end
            4'b0001: begin
               if (n_ref < 16) ref_t[n_ref] = cyc;
               n_ref++; aft_ref_t = -1;
            end
            4'b0000: begin mrs_t = cyc; mrs_addr = sd_addr; mrs_ba = sd_ba; end
            default: ;
         endcase
         if (wr_data_en) begin
            if (wr_n[k] == 0) wr_first[k] = cyc;
            wr_n[k]++; wr_last[k] = cyc;
         end
         if (rd_data_valid) begin
            if (rd_n[k] == 0) rd_first[k] = cyc;
            rd_n[k]++;
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic issue(input logic [24:0] v);
      @(negedge clk);
      req_valid = 1'b1;
      {req_write, req_bank, req_row, req_col} = v;
      while (!req_ready) @(negedge clk);
      @(posedge clk);
      #1;
      check(req_ready == 1'b0, "R10 ready drops after take", req_ready, 0);
   endtask

   always @(posedge clk) begin
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_bank = '0; req_row = '0; req_col = '0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 pins NOP in reset",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 7);
      check(req_ready == 0 && init_done == 0, "R1 ready/init low", {req_ready, init_done}, 0);
      check(wr_data_en == 0 && rd_data_valid == 0, "R1 strobes low",
            {wr_data_en, rd_data_valid}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111 && !req_ready && !init_done,
            "R1 NOP during power-up wait", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 7);

      // table of accesses, issued back to back
      for (int i = 0; i < NV; i++) issue(VEC[i]);
      @(negedge clk) req_valid = 1'b0;
      repeat (20) @(negedge clk);

      // R2 initialisation sequence
      check(pa_t >= PWR, "R2 precharge-all after power-up", pa_t, PWR);
      check(ref_t[0] - pa_t == 3, "R2 first refresh spacing", ref_t[0] - pa_t, 3);
      check(ref_t[1] - ref_t[0] == 9, "R2 second refresh spacing", ref_t[1] - ref_t[0], 9);
      check(mrs_t - ref_t[1] == 9, "R2 mode set spacing", mrs_t - ref_t[1], 9);
      check(mrs_addr == 'h032 && mrs_ba == 0, "R2 mode word", mrs_addr, 'h032);
      check(act_t[0] - mrs_t == 2, "R7 first command after mode set", act_t[0] - mrs_t, 2);

      for (int i = 0; i < NV; i++) begin
         logic        w;
         logic [1:0]  b;
         logic [12:0] r;
         logic [8:0]  c;
         {w, b, r, c} = VEC[i];
         check(act_row[i] == r && act_ba[i] == b, "R3 row and bank on ACTIVE", act_row[i], r);
         check(col_t[i] - act_t[i] == 3, "R3 ACTIVE to column", col_t[i] - act_t[i], 3);
         check(col_wr[i] == w, "R3 column command type", col_wr[i], w);
         check(col_addr[i] == {4'b0, c} && col_ba[i] == b, "R3 column, bank, bit 10 low",
               col_addr[i], {4'b0, c});
         check(pre_ba[i] == b && pre_a10[i] == 0, "R11 single-bank close", pre_ba[i], b);
         if (w) begin
            check(wr_n[i] == 4 && wr_first[i] == col_t[i], "R4 write beats", wr_n[i], 4);
            check(pre_t[i] - wr_last[i] == 2, "R4 recovery after last beat",
                  pre_t[i] - wr_last[i], 2);
            check(pre_t[i] - act_t[i] >= 6, "R4 row active minimum", pre_t[i] - act_t[i], 6);
            check(rd_n[i] == 0, "R5 no read strobe on write", rd_n[i], 0);
         end else begin
            check(rd_n[i] == 4, "R5 read beats", rd_n[i], 4);
            check(rd_first[i] - col_t[i] == 3, "R5 CAS latency", rd_first[i] - col_t[i], 3);
            check(pre_t[i] - col_t[i] == 4, "R5 read to precharge", pre_t[i] - col_t[i], 4);
            check(wr_n[i] == 0, "R5 no write strobe on read", wr_n[i], 0);
         end
         if (i > 0) begin
            int exp_gap;
            exp_gap = VEC[i-1][24] ? 11 : 10;
            check(act_t[i] - act_t[i-1] == exp_gap, "R6 ACTIVE to ACTIVE",
                  act_t[i] - act_t[i-1], exp_gap);
         end
      end
      check(n_act == NV, "R10 one ACTIVE per request", n_act, NV);

      // R8 idle refresh period
      while (n_ref < 4) @(negedge clk);
      check(ref_t[3] - ref_t[2] == 1040, "R8 idle refresh period", ref_t[3] - ref_t[2], 1040);

      // R9 refresh wins over a continuous request stream
      begin
         int j = 0;
         while (n_ref < 5) begin
            issue({j[0], j[2:1], 13'h0100 + 13'(j), 9'(j)});
            j++;
         end
      end
      @(negedge clk) req_valid = 1'b0;
      repeat (15) @(negedge clk);
      check(ref_t[4] - ref_t[3] >= 1040 && ref_t[4] - ref_t[3] <= 1051,
            "R9 refresh under load", ref_t[4] - ref_t[3], 1040);
      check(aft_ref_t - ref_t[4] == 9, "R8 row cycle after refresh", aft_ref_t - ref_t[4], 9);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule